// File: doc/BRIEF.md
# Synchronous serial I/O controller

This block is a byte-wide clocked serial shift unit for a microcontroller peripheral bus. The CPU loads an 8-bit shift buffer and writes an 8-bit mode register that picks the bit order, the direction and the serial clock source. It then sets a self-clearing start bit. The unit sends the buffer out on `so`, one bit per serial clock cycle. At the same time it shifts the level sampled on `si` into the buffer. After the eighth bit it stops and raises an interrupt request flag.

The serial clock comes from one of several places. It can be an external clock on `sck_in`, a timer tick, the CPU clock enable, or one of two fixed divisions of the system clock. With an internal source the block drives `sck_out` and raises `sck_oe`. With the external source it synchronizes `sck_in` into the system clock domain and acts on the edges it detects. `so` changes on falling serial clock edges, and `si` is sampled on rising edges. CPU access to the buffer is gated against active shifting. Reads and writes that are blocked are dropped.

Top module: `sio_ctrl`

## Requirements
- R1: After reset `irq` is 0, `sck_out` is 1, `so` is 1, `buf_rdata` is 0 and `sck_oe` is 0, because the mode register clears to zero and clock code 000 selects the external clock.
- R2: Mode bit 0 sets the bit order. With 0 the most significant bit is sent first and the first received bit ends in bit 7. With 1 the least significant bit is sent first and the first received bit ends in bit 0. In both orders, after eight bits the buffer reads back the received byte.
- R3: Mode bit 1 = 0 selects receive-only. `so` then stays 1 at every falling edge, while `si` is still shifted in. Mode bit 1 = 1 sends the buffer on `so`.
- R4: The bit order used for a transfer is the value of mode bit 0 when the buffer was last loaded. A later change of bit 0 affects only the next load.
- R5: After the eighth rising edge shifting stops, `sck_out` idles high and `irq` becomes 1. With the CPU clock enable held high, `irq` rises on the 17th clock edge after the edge that writes the start bit.
- R6: Writing 1 to mode bit 3, through `mode_wr` or through the single-bit strobe `start_set`, clears `irq` by the next edge and starts one transfer. The bit then clears itself, so no second transfer follows without a new start.
- R7: Mode bits 7:5 pick the clock. 001 is the timer tick, 01x the CPU clock enable, 100 gives a serial clock period of DIV_SLOW system cycles and 111 a period of DIV_FAST cycles. Each tick toggles the serial clock. Code 111 while `cpu_div64` is 1 produces no clock, and codes 101 and 110 produce no clock.
- R8: Code 000 takes the serial clock from `sck_in` through a synchronizer, with `sck_oe` 0. All other codes drive `sck_out` with `sck_oe` 1.
- R9: With mode bit 2 = 0 the shifter and bit counter do not run, no serial clock edges are produced, and `irq` keeps its value.
- R10: With the CPU clock source, buffer reads and writes are accepted at any time. With any other source they are accepted only when no transfer is running or while the serial clock is high. A blocked read leaves `buf_rdata` unchanged, and a blocked write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Full write of the mode register |
| mode_wdata | input | 8 | Mode value: 7:5 clock code, 3 start, 2 enable, 1 transmit, 0 LSB first |
| start_set | input | 1 | Single-bit write of 1 to the start bit |
| buf_wr | input | 1 | Buffer write request |
| buf_wdata | input | W | Buffer write data |
| buf_rd | input | 1 | Buffer read request |
| buf_rdata | output | W | Registered buffer read data |
| cpu_tick | input | 1 | CPU clock enable pulse |
| cpu_div64 | input | 1 | CPU clock is at its slowest setting |
| tmr_tick | input | 1 | Timer output tick |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Driven serial clock, idles high |
| sck_oe | output | 1 | Serial clock is driven by this block |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| irq | output | 1 | Transfer-complete request flag |

## Verification
Each check is timed to the registers on its path. `so` is registered at the same edge that drops `sck_out`, so the bench compares it at the falling edge where it sees the fall. With the external clock, a level change takes three edges through the synchronizer and shifter, so the bench holds each phase for six cycles before it compares. A read shows up in `buf_rdata` one edge after the request. The completion latency is counted as exactly 17 edges from the start write with the CPU clock enable held high. For the other sources the bench measures the serial clock period as the gap between two falling edges and compares it with the divider or tick spacing.

// File: rtl/sio_pkg.sv
package sio_pkg;

  // Clock source codes held in mode bits 7:5
  typedef enum logic [2:0] {
    CS_EXT  = 3'b000,
    CS_TMR  = 3'b001,
    CS_CPU0 = 3'b010,
    CS_CPU1 = 3'b011,
    CS_SLOW = 3'b100,
    CS_RSV0 = 3'b101,
    CS_RSV1 = 3'b110,
    CS_FAST = 3'b111
  } clk_sel_e;

  localparam int MODE_W = 8;
  // Bit 4 is unused and bit 3 (start) is not stored in the mode register
  localparam logic [MODE_W-1:0] MODE_KEEP = 8'hE7;

  function automatic logic is_cpu_src(clk_sel_e s);
    return (s == CS_CPU0) || (s == CS_CPU1);
  endfunction

endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen
  import sio_pkg::*;
#(
  parameter int DIV_SLOW = 1024,
  parameter int DIV_FAST = 16,
  parameter int SYNC_N   = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  clk_sel_e sel,
  input  logic     cpu_div64,
  input  logic     cpu_tick,
  input  logic     tmr_tick,
  input  logic     sck_in,
  input  logic     run,
  output logic     fall_ev,
  output logic     rise_ev,
  output logic     sck_lvl,
  output logic     sck_out,
  output logic     sck_oe
);

  localparam int HALF_S = DIV_SLOW / 2;
  localparam int HALF_F = DIV_FAST / 2;
  localparam int PW     = $clog2(HALF_S);
  localparam int FW     = $clog2(HALF_F);

  logic [PW-1:0]   pre_q;
  logic            slow_tick, fast_tick, tick, int_src;
  logic            sck_q;
  logic [SYNC_N:0] sync_q;
  logic            ext_lvl, ext_prev;

  // Free-running prescaler shared by both fixed divisions
  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  assign slow_tick = &pre_q;
  assign fast_tick = &pre_q[FW-1:0];
  assign int_src   = (sel != CS_EXT);

  always_comb begin
    case (sel)
      CS_TMR:           tick = tmr_tick;
      CS_CPU0, CS_CPU1: tick = cpu_tick;
      CS_SLOW:          tick = slow_tick;
      CS_FAST:          tick = fast_tick & ~cpu_div64;
      default:          tick = 1'b0;
    endcase
  end

  // Internal serial clock: idles high, toggles on every source tick
  always_ff @(posedge clk) begin
    if (rst)                  sck_q <= 1'b1;
    else if (!run)            sck_q <= 1'b1;
    else if (int_src && tick) sck_q <= ~sck_q;
  end

  // External clock synchronizer with one extra stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_N-1:0], sck_in};
  end

  assign ext_lvl  = sync_q[SYNC_N-1];
  assign ext_prev = sync_q[SYNC_N];

  assign fall_ev = run & (int_src ? (tick & sck_q)  : (ext_prev & ~ext_lvl));
  assign rise_ev = run & (int_src ? (tick & ~sck_q) : (~ext_prev & ext_lvl));
  assign sck_lvl = int_src ? sck_q : ext_lvl;
  assign sck_out = sck_q;
  assign sck_oe  = int_src;

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int W  = 8,
  parameter int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ldata,
  input  logic         lsb_sel,
  input  logic         clr_cnt,
  input  logic         fall_ev,
  input  logic         rise_ev,
  input  logic         si,
  input  logic         txen,
  output logic [W-1:0] data,
  output logic         so,
  output logic         wrap
);

  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sreg;
  logic [CW-1:0] cnt;
  logic          lsb_q;
  logic          so_q;

  // Buffer: a CPU load wins over shifting; the order is latched with the load
  always_ff @(posedge clk) begin
    if (rst) begin
      sreg  <= '0;
      lsb_q <= 1'b0;
    end else if (load) begin
      sreg  <= ldata;
      lsb_q <= lsb_sel;
    end else if (rise_ev) begin
      sreg <= lsb_q ? {si, sreg[W-1:1]} : {sreg[W-2:0], si};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (clr_cnt) cnt <= '0;
    else if (rise_ev) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          so_q <= 1'b1;
    else if (fall_ev) so_q <= txen ? (lsb_q ? sreg[0] : sreg[W-1]) : 1'b1;
  end

  assign data = sreg;
  assign so   = so_q;
  assign wrap = rise_ev & ~clr_cnt & (cnt == LAST);

endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int W        = 8,
  parameter int DIV_SLOW = 1024,
  parameter int DIV_FAST = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_wr,
  input  logic [7:0]   mode_wdata,
  input  logic         start_set,
  input  logic         buf_wr,
  input  logic [W-1:0] buf_wdata,
  input  logic         buf_rd,
  output logic [W-1:0] buf_rdata,
  input  logic         cpu_tick,
  input  logic         cpu_div64,
  input  logic         tmr_tick,
  input  logic         sck_in,
  output logic         sck_out,
  output logic         sck_oe,
  input  logic         si,
  output logic         so,
  output logic         irq
);

  logic [MODE_W-1:0] mode_q;
  logic              start_q, busy_q, irq_q;
  logic [W-1:0]      rdata_q;
  logic              start_req, run, acc_ok, load;
  logic              fall_ev, rise_ev, sck_lvl, wrap;
  logic [W-1:0]      sh_data;
  clk_sel_e          mode_sel;
  logic              mode_en, mode_txen, mode_lsb;

  assign mode_sel  = clk_sel_e'(mode_q[7:5]);
  assign mode_en   = mode_q[2];
  assign mode_txen = mode_q[1];
  assign mode_lsb  = mode_q[0];

  assign start_req = start_set | (mode_wr & mode_wdata[3]);
  assign run       = busy_q & mode_en;
  assign acc_ok    = is_cpu_src(mode_sel) | ~busy_q | sck_lvl;
  assign load      = buf_wr & acc_ok;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (mode_wr) mode_q <= mode_wdata & MODE_KEEP;
  end

  // Start, busy and completion flag; a start write has the last word
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wrap) begin
        busy_q <= 1'b0;
        irq_q  <= 1'b1;
      end
      if (start_req) begin
        start_q <= 1'b1;
        irq_q   <= 1'b0;
      end else if (start_q && mode_en) begin
        start_q <= 1'b0;
        busy_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (buf_rd && acc_ok) rdata_q <= sh_data;
  end

  sio_clkgen #(
    .DIV_SLOW(DIV_SLOW),
    .DIV_FAST(DIV_FAST)
  ) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .sel      (mode_sel),
    .cpu_div64(cpu_div64),
    .cpu_tick (cpu_tick),
    .tmr_tick (tmr_tick),
    .sck_in   (sck_in),
    .run      (run),
    .fall_ev  (fall_ev),
    .rise_ev  (rise_ev),
    .sck_lvl  (sck_lvl),
    .sck_out  (sck_out),
    .sck_oe   (sck_oe)
  );

  sio_shifter #(.W(W)) u_shifter (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .ldata  (buf_wdata),
    .lsb_sel(mode_lsb),
    .clr_cnt(start_req),
    .fall_ev(fall_ev),
    .rise_ev(rise_ev),
    .si     (si),
    .txen   (mode_txen),
    .data   (sh_data),
    .so     (so),
    .wrap   (wrap)
  );

  assign buf_rdata = rdata_q;
  assign irq       = irq_q;

endmodule

// File: rtl/sio_ctrl_chk.sv
module sio_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       irq,
  input logic       sck_out,
  input logic       so,
  input logic       fall_ev,
  input logic       rise_ev,
  input logic       txen,
  input logic [2:0] sel,
  input logic       cpu_div64,
  input logic       start_req
);

  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $fell(busy)); // R5

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sck_out); // R5

  AST_RXONLY_SO: assert property (@(posedge clk) disable iff (rst)
    $past(fall_ev && !txen) |-> so); // R3

  AST_START_CLR: assert property (@(posedge clk) disable iff (rst)
    $past(start_req) |-> !irq); // R6

  AST_NO_CLOCK: assert property (@(posedge clk) disable iff (rst)
    ((sel == 3'b111 && cpu_div64) || sel == 3'b101 || sel == 3'b110)
      |-> !(fall_ev || rise_ev)); // R7

endmodule

bind sio_ctrl sio_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy_q),
  .irq      (irq_q),
  .sck_out  (sck_out),
  .so       (so),
  .fall_ev  (fall_ev),
  .rise_ev  (rise_ev),
  .txen     (mode_txen),
  .sel      (mode_q[7:5]),
  .cpu_div64(cpu_div64),
  .start_req(start_req)
);

// File: tb/sio_ctrl_bench.sv
module sio_ctrl_bench;

  localparam int W  = 8;
  localparam int DS = 64;
  localparam int DF = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_wr = 1'b0;
  logic [7:0]   mode_wdata = '0;
  logic         start_set = 1'b0;
  logic         buf_wr = 1'b0;
  logic [W-1:0] buf_wdata = '0;
  logic         buf_rd = 1'b0;
  logic [W-1:0] buf_rdata;
  logic         cpu_tick = 1'b0;
  logic         cpu_div64 = 1'b0;
  logic         tmr_tick = 1'b0;
  logic         sck_in = 1'b1;
  logic         sck_out, sck_oe;
  logic         si = 1'b0;
  logic         so, irq;

  int n_chk = 0;
  int n_err = 0;
  int cpu_div = 1;
  bit finished = 0;

  always #5 clk = ~clk;

  sio_ctrl #(.W(W), .DIV_SLOW(DS), .DIV_FAST(DF)) u_sio_ctrl (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .start_set(start_set), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .buf_rd(buf_rd), .buf_rdata(buf_rdata), .cpu_tick(cpu_tick),
    .cpu_div64(cpu_div64), .tmr_tick(tmr_tick), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .si(si), .so(so), .irq(irq)
  );

  // Tick sources: timer every 5 cycles, CPU enable every cpu_div cycles
  initial begin
    int tcnt = 0;
    int ccnt = 0;
    forever begin
      @(negedge clk);
      tmr_tick = (tcnt == 0);
      tcnt = (tcnt == 4) ? 0 : tcnt + 1;
      cpu_tick = (ccnt == 0);
      ccnt = (ccnt >= cpu_div - 1) ? 0 : ccnt + 1;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic [2:0] sel, input bit st,
                                    input bit en, input bit tx, input bit lsb);
    return {sel, 1'b0, st, en, tx, lsb};
  endfunction

  // All tasks are entered and left at a falling clock edge
  task automatic wr_mode(input logic [7:0] m);
    mode_wr = 1'b1; mode_wdata = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic wr_buf(input logic [7:0] d);
    buf_wr = 1'b1; buf_wdata = d;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic rd_buf(output logic [7:0] d);
    buf_rd = 1'b1;
    @(negedge clk);
    buf_rd = 1'b0;
    d = buf_rdata;
  endtask

  task automatic watch(input int n, output int falls);
    logic prev = sck_out;
    falls = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (prev && !sck_out) falls++;
      prev = sck_out;
    end
  endtask

  // Full transfer with an internal source; checks SO per bit and RX byte
  task automatic xfer(input logic [7:0] start_mode, input logic [7:0] tx,
                      input logic [7:0] rx, input bit eff_lsb, input bit txen,
                      input bit chk_lat);
    logic prev = 1'b1;
    int k = 0;
    int cyc = 0;
    logic [7:0] got;
    wr_mode(start_mode);
    chk("R6", "irq cleared by start", irq, 0);
    while (!irq && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (prev && !sck_out) begin
        if (k < 8) begin
          chk(eff_lsb ? "R2" : "R4", "so bit", so,
              txen ? (eff_lsb ? tx[k] : tx[7-k]) : 1);
          if (!txen) chk("R3", "rx-only so", so, 1);
          si = eff_lsb ? rx[k] : rx[7-k];
        end
        k++;
      end
      prev = sck_out;
    end
    chk("R5", "irq set", irq, 1);
    chk("R5", "eight falls", k, 8);
    if (chk_lat) chk("R5", "latency", cyc, 17);
    chk("R5", "sck idle high", sck_out, 1);
    rd_buf(got);
    chk("R2", "rx byte", got, rx);
  endtask

  task automatic period_run(input logic [2:0] sel, input int exp_per);
    logic prev = 1'b1;
    int cyc = 0;
    int t1 = -1;
    int t2 = -1;
    wr_mode(mk(sel, 0, 1, 1, 0));
    wr_buf(8'h96);
    wr_mode(mk(sel, 1, 1, 1, 0));
    chk("R8", "sck_oe internal", sck_oe, 1);
    while (!irq && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (prev && !sck_out) begin
        if (t1 < 0) t1 = cyc;
        else if (t2 < 0) t2 = cyc;
      end
      prev = sck_out;
    end
    chk("R7", "sck period", t2 - t1, exp_per);
    chk("R7", "done", irq, 1);
  endtask

  // Access gating during a transfer, MSB first, T=C3, RX=5A
  task automatic gate_run(input logic [2:0] sel, input bit cpu_ok);
    logic [7:0] tx = 8'hC3;
    logic [7:0] rx = 8'h5A;
    logic [7:0] v;
    logic prev = 1'b1;
    int nf = 0;
    int nr = 0;
    int cyc = 0;
    wr_mode(mk(sel, 0, 1, 1, 0));
    wr_buf(tx);
    rd_buf(v);
    chk("R10", "idle read", v, tx);
    wr_mode(mk(sel, 1, 1, 1, 0));
    while (!irq && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (prev && !sck_out) begin
        nf++;
        si = rx[8-nf];
        if (nf == 2) begin
          rd_buf(v);
          chk("R10", "read in low phase", v,
              cpu_ok ? {tx[6:0], rx[7]} : tx);
        end
        if (nf == 3) wr_buf(8'h55);
      end else if (!prev && sck_out) begin
        nr++;
        if (nr == 2) begin
          rd_buf(v);
          chk("R10", "read in high phase", v, {tx[5:0], rx[7], rx[6]});
        end
      end
      prev = sck_out;
    end
    chk("R10", "gated done", irq, 1);
    rd_buf(v);
    chk("R10", "write in low phase", v, cpu_ok ? {2'b01, rx[5:0]} : rx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int falls;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "irq", irq, 0);
    chk("R1", "sck_out", sck_out, 1);
    chk("R1", "so", so, 1);
    chk("R1", "rdata", buf_rdata, 0);
    chk("R1", "sck_oe", sck_oe, 0);

    // R2/R3/R5 sweep with the CPU clock every cycle
    for (int lsb = 0; lsb < 2; lsb++) begin
      for (int tx = 0; tx < 2; tx++) begin
        for (int p = 0; p < 4; p++) begin
          logic [7:0] tpat = 8'(p * 77 + 19 + lsb * 3);
          logic [7:0] rpat = 8'(p * 53 + 200 + tx * 5);
          wr_mode(mk(3'b010, 0, 1, tx[0], lsb[0]));
          wr_buf(tpat);
          xfer(mk(3'b010, 1, 1, tx[0], lsb[0]), tpat, rpat, lsb[0], tx[0], 1);
        end
      end
    end

    // R6 the start bit cleared itself: nothing more happens
    watch(40, falls);
    chk("R6", "no second transfer", falls, 0);
    chk("R6", "irq held", irq, 1);

    // R6 single-bit start strobe
    wr_buf(8'hE1);
    start_set = 1'b1;
    @(negedge clk);
    start_set = 1'b0;
    chk("R6", "strobe clears irq", irq, 0);
    watch(60, falls);
    chk("R6", "strobe transfer falls", falls, 8);
    chk("R6", "strobe transfer done", irq, 1);

    // R4 order latched at load: load MSB-first, start with LSB bit set
    wr_mode(mk(3'b010, 0, 1, 1, 0));
    wr_buf(8'h2D);
    xfer(mk(3'b010, 1, 1, 1, 1), 8'h2D, 8'hB4, 0, 1, 1);
    // and the reverse
    wr_mode(mk(3'b010, 0, 1, 1, 1));
    wr_buf(8'h71);
    xfer(mk(3'b010, 1, 1, 1, 0), 8'h71, 8'h0E, 1, 1, 1);

    // R7 clock sources
    period_run(3'b001, 10);
    period_run(3'b100, DS);
    period_run(3'b111, DF);
    cpu_div = 3;
    period_run(3'b011, 6);

    // R10 access gating
    gate_run(3'b100, 0);
    cpu_div = 4;
    gate_run(3'b010, 1);
    cpu_div = 1;

    // R8 external clock
    wr_mode(mk(3'b000, 0, 1, 1, 0));
    wr_buf(8'hA7);
    wr_mode(mk(3'b000, 1, 1, 1, 0));
    chk("R8", "sck_oe external", sck_oe, 0);
    for (int k = 0; k < 8; k++) begin
      sck_in = 1'b0;
      repeat (6) @(negedge clk);
      chk("R8", "ext so bit", so, 8'hA7 >> (7 - k) & 1);
      si = 8'h3B >> (7 - k) & 1;
      sck_in = 1'b1;
      repeat (6) @(negedge clk);
    end
    chk("R8", "ext done", irq, 1);
    rd_buf(v);
    chk("R8", "ext rx", v, 8'h3B);

    // R9 disabled shifter keeps irq and makes no clock
    wr_mode(mk(3'b010, 0, 0, 1, 0));
    watch(30, falls);
    chk("R9", "no clock when disabled", falls, 0);
    chk("R9", "irq retained", irq, 1);
    wr_mode(mk(3'b010, 1, 0, 1, 0));
    chk("R9", "start clears irq when disabled", irq, 0);
    watch(30, falls);
    chk("R9", "still no clock", falls, 0);
    chk("R9", "irq stays low", irq, 0);

    // R7 forbidden and reserved clock codes
    cpu_div64 = 1'b1;
    wr_mode(mk(3'b111, 1, 1, 1, 0));
    watch(200, falls);
    chk("R7", "fast with div64 no clock", falls, 0);
    chk("R7", "fast with div64 no irq", irq, 0);
    cpu_div64 = 1'b0;
    wr_mode(mk(3'b101, 1, 1, 1, 0));
    watch(200, falls);
    chk("R7", "code 101 no clock", falls, 0);
    wr_mode(mk(3'b110, 1, 1, 1, 0));
    watch(200, falls);
    chk("R7", "code 110 no clock", falls, 0);
    chk("R7", "reserved no irq", irq, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule